// File: doc/BRIEF.md
# Serial EEPROM Station-Address Loader

This block is a hardware master for a three-wire serial EEPROM with 16-bit words. On a start pulse it reads a 48-bit station address from the EEPROM and presents it on a parallel output. It drives chip select, a shift clock and a serial data line into the memory, and it samples the serial data line coming back.

The EEPROM may use 6-bit or 8-bit word addresses, and the block finds out which. It first reads word 0 using an 8-bit address. If that word equals a signature value, the block uses 8-bit addressing for the rest of the sequence. Otherwise it uses 6-bit addressing. It then reads three consecutive words and assembles them into the address, low word first. A done pulse marks the end of the sequence, and a level output reports the address width that was detected.

The serial clock is derived from the system clock. A parameter sets how many system clocks make up each half of the serial clock period, so the serial clock can be kept slow enough for the memory.

Top module: `ee_addr_loader`

## Requirements
- R1: Each read frame shifts out, MSB first on `eeDi`, the bits 1,1,0 followed by the word address. The frame is 11 bits long with 8-bit addressing and 9 bits long with 6-bit addressing. The first frame of a sequence always uses 8-bit addressing and word address 0.
- R2: `wideAddr` is 1 if word 0, read with 8-bit addressing, equals `SIG_WORD` (default 16'h8129). Otherwise it is 0, and the three later frames then use 6-bit addressing.
- R3: The three later frames read word addresses `FIRST_WORD`, `FIRST_WORD`+1 and `FIRST_WORD`+2 (default 7, 8, 9). Their data is placed in `stationAddr[15:0]`, `[31:16]` and `[47:32]` respectively. Each word's low byte therefore lands at the lower byte position, so `stationAddr[7:0]` is the low byte of word 7.
- R4: After the command bits there is one half-period with the clock low. Then exactly 16 rising edges of `eeSk` follow. On each of them one data bit is taken from `eeDo`, MSB first, sampled at the end of the clock-high half. A whole sequence therefore has 27 + 3×(19 + address width) rising edges.
- R5: `eeDi` changes only while `eeSk` is low. It holds its value for the whole time `eeSk` is high.
- R6: `eeCs` is low for at least one half-period before and after each frame. It rises and falls only while `eeSk` is low.
- R7: Every high half and every low half of `eeSk` lasts exactly `HALF_DIV` system clocks.
- R8: `done` is high for exactly one cycle when the third address word has been stored. `busy` is high from the cycle after an accepted start until `done`, and it is low in the cycle where `done` is high.
- R9: A `start` that arrives while `busy` is high has no effect. The running sequence keeps its length, its frames and its single `done` pulse.
- R10: After reset, `eeCs`, `eeSk`, `eeDi`, `busy`, `done`, `wideAddr` and `stationAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load sequence (accepted when idle) |
| eeDo | input | 1 | Serial data coming back from the EEPROM |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSk | output | 1 | EEPROM shift clock |
| eeDi | output | 1 | Serial command data going to the EEPROM |
| stationAddr | output | 48 | Assembled station address |
| wideAddr | output | 1 | 1 when 8-bit word addressing was detected |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
A wrong phase or bit counter shows at the ports within one frame, which takes a few dozen half-periods. It shows as a wrong number of rising edges on `eeSk`, or as a command whose opcode or address is misaligned; the memory model captures and decodes every command. A wrong width decision shows as soon as the second frame starts, because that frame is two bits shorter or longer than expected. A fault in word placement or byte order shows only at `done`, as a mismatch between `stationAddr` and the words the bench holds. Several word patterns are read with both address widths, so a swapped or shifted slice cannot escape.

// File: rtl/ee_loader_pkg.sv
package ee_loader_pkg;
  localparam int WORD_W        = 16;
  localparam int OP_W          = 3;
  localparam int ADDR_W_WIDE   = 8;
  localparam int ADDR_W_NARROW = 6;
  localparam int CMD_W         = OP_W + ADDR_W_WIDE;
  localparam int NUM_WORDS     = 3;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CSOFF, PH_CSON, PH_CMDLO, PH_CMDHI,
    PH_GAP, PH_DATHI, PH_DATLO, PH_END
  } phase_t;

  typedef struct packed {
    logic clearAll;
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic storeWord;
  } dpStrobe_t;
endpackage

// File: rtl/ee_loader_ctrl.sv
module ee_loader_ctrl
  import ee_loader_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wideMode,
  output dpStrobe_t  strobe,
  output logic [1:0] wordIdx,
  output logic       useWide,
  output logic       cmdPhase,
  output logic       eeCs,
  output logic       eeSk,
  output logic       busy,
  output logic       done
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(OP_W + ADDR_W_WIDE - 1);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(OP_W + ADDR_W_NARROW - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(WORD_W - 1);
  localparam logic [1:0]       LAST_IDX   = 2'(NUM_WORDS);

  phase_t            phase, phaseNext;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt, bitNext;
  logic [1:0]        idxNext;
  logic              doneNext;
  logic              tick;

  assign tick    = (divCnt == DIV_W'(HALF_DIV - 1));
  assign useWide = (wordIdx == 2'd0) || wideMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (phase == PH_IDLE || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    phaseNext = phase;
    bitNext   = bitCnt;
    idxNext   = wordIdx;
    doneNext  = 1'b0;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        phaseNext       = PH_CSOFF;
        idxNext         = 2'd0;
        strobe.clearAll = 1'b1;
      end
      PH_CSOFF: if (tick) begin
        phaseNext      = PH_CSON;
        strobe.loadCmd = 1'b1;
        bitNext        = useWide ? LEN_WIDE : LEN_NARROW;
      end
      PH_CSON:  if (tick) phaseNext = PH_CMDLO;
      PH_CMDLO: if (tick) phaseNext = PH_CMDHI;
      PH_CMDHI: if (tick) begin
        if (bitCnt == '0) phaseNext = PH_GAP;
        else begin
          strobe.shiftCmd = 1'b1;
          bitNext         = bitCnt - 1'b1;
          phaseNext       = PH_CMDLO;
        end
      end
      PH_GAP: if (tick) begin
        phaseNext = PH_DATHI;
        bitNext   = DATA_LAST;
      end
      PH_DATHI: if (tick) begin
        strobe.sampleBit = 1'b1;
        phaseNext        = PH_DATLO;
      end
      PH_DATLO: if (tick) begin
        if (bitCnt == '0) phaseNext = PH_END;
        else begin
          bitNext   = bitCnt - 1'b1;
          phaseNext = PH_DATHI;
        end
      end
      PH_END: if (tick) begin
        strobe.storeWord = 1'b1;
        if (wordIdx == LAST_IDX) begin
          phaseNext = PH_IDLE;
          doneNext  = 1'b1;
        end else begin
          idxNext   = wordIdx + 1'b1;
          phaseNext = PH_CSOFF;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      wordIdx <= '0;
      done    <= 1'b0;
    end else begin
      phase   <= phaseNext;
      bitCnt  <= bitNext;
      wordIdx <= idxNext;
      done    <= doneNext;
    end
  end

  assign eeCs     = phase inside {PH_CSON, PH_CMDLO, PH_CMDHI, PH_GAP, PH_DATHI, PH_DATLO};
  assign eeSk     = phase inside {PH_CMDHI, PH_DATHI};
  assign cmdPhase = phase inside {PH_CMDLO, PH_CMDHI};
  assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/ee_loader_dp.sv
module ee_loader_dp
  import ee_loader_pkg::*;
#(
  parameter logic [WORD_W-1:0] SIG_WORD   = 16'h8129,
  parameter int                FIRST_WORD = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [1:0]                  wordIdx,
  input  logic                        useWide,
  input  logic                        cmdPhase,
  input  logic                        eeDo,
  output logic                        eeDi,
  output logic                        wideMode,
  output logic [NUM_WORDS*WORD_W-1:0] stationAddr
);
  localparam logic [OP_W-1:0] READ_OP = 3'b110;

  logic [CMD_W-1:0]       cmdReg;
  logic [WORD_W-1:0]      dataReg;
  logic [ADDR_W_WIDE-1:0] frameAddr;

  assign frameAddr = (wordIdx == 2'd0) ? '0 :
                     ADDR_W_WIDE'(FIRST_WORD) + ADDR_W_WIDE'(wordIdx) - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (strobe.loadCmd)
      cmdReg <= useWide ? {READ_OP, frameAddr}
                        : {READ_OP, frameAddr[ADDR_W_NARROW-1:0],
                           {(ADDR_W_WIDE-ADDR_W_NARROW){1'b0}}};
    else if (strobe.shiftCmd) cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
  end

  assign eeDi = cmdPhase & cmdReg[CMD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else if (strobe.sampleBit) dataReg <= {dataReg[WORD_W-2:0], eeDo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wideMode <= 1'b0;
    else if (strobe.clearAll) wideMode <= 1'b0;
    else if (strobe.storeWord && wordIdx == 2'd0) wideMode <= (dataReg == SIG_WORD);
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    logic [WORD_W-1:0] wordReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordReg <= '0;
      else if (strobe.clearAll) wordReg <= '0;
      else if (strobe.storeWord && wordIdx == 2'(g + 1)) wordReg <= dataReg;
    end
    assign stationAddr[g*WORD_W +: WORD_W] = wordReg;
  end
endmodule

// File: rtl/ee_addr_loader.sv
module ee_addr_loader
  import ee_loader_pkg::*;
#(
  parameter int                HALF_DIV   = 25,
  parameter logic [15:0]       SIG_WORD   = 16'h8129,
  parameter int                FIRST_WORD = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        eeDo,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  output logic [47:0] stationAddr,
  output logic        wideAddr,
  output logic        busy,
  output logic        done
);
  dpStrobe_t  strobe;
  logic [1:0] wordIdx;
  logic       useWide;
  logic       cmdPhase;

  ee_loader_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wideMode(wideAddr),
    .strobe(strobe), .wordIdx(wordIdx), .useWide(useWide),
    .cmdPhase(cmdPhase), .eeCs(eeCs), .eeSk(eeSk),
    .busy(busy), .done(done)
  );

  ee_loader_dp #(.SIG_WORD(SIG_WORD), .FIRST_WORD(FIRST_WORD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .useWide(useWide), .cmdPhase(cmdPhase), .eeDo(eeDo),
    .eeDi(eeDi), .wideMode(wideAddr), .stationAddr(stationAddr)
  );
endmodule

// File: rtl/ee_addr_loader_chk.sv
module ee_addr_loader_chk #(
  parameter int HALF_DIV = 25
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi,
  input logic busy,
  input logic done
);
  logic [15:0] hiCnt;
  logic [15:0] loCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else begin
      hiCnt <= eeSk ? hiCnt + 1'b1 : '0;
      loCnt <= (eeCs && !eeSk) ? loCnt + 1'b1 : '0;
    end
  end

  // R5: data held while the clock is high
  assert_di_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));

  // R6: select edges only with clock low
  assert_cs_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eeCs) || $fell(eeCs)) |-> (!eeSk && !$past(eeSk)));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!eeCs && !eeSk));

  // R7: clock-high half length
  assert_hi_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeSk) |-> (hiCnt == 16'(HALF_DIV)));

  // R7: clock-low half length inside a frame
  assert_lo_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eeSk) && $past(eeCs)) |-> (loCnt == 16'(HALF_DIV) || loCnt == 16'(2*HALF_DIV)));

  // R8: done is a single pulse with busy low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9: start while busy does not restart or end the sequence
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> (busy || done));
endmodule

bind ee_addr_loader ee_addr_loader_chk #(.HALF_DIV(HALF_DIV)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .eeCs(eeCs), .eeSk(eeSk),
  .eeDi(eeDi), .busy(busy), .done(done)
);

// File: tb/ee_addr_loader_test.sv
module ee_addr_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int FIRST      = 7;
  localparam logic [15:0] SIG = 16'h8129;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic eeDo = 1'b0;
  logic eeCs, eeSk, eeDi, wideAddr, busy, done;
  logic [47:0] stationAddr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_addr_loader #(.HALF_DIV(HALF), .SIG_WORD(SIG), .FIRST_WORD(FIRST)) uut (
    .clk(clk), .rstN(rstN), .start(start), .eeDo(eeDo),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .stationAddr(stationAddr),
    .wideAddr(wideAddr), .busy(busy), .done(done)
  );

  // EEPROM model
  int          devAw = 8;
  logic [15:0] mem [0:255];
  int          edgeCnt = 0;
  int          frameNo = 0;
  int          runBase = 0;
  int          edgeTotal = 0;
  int          cmdErr = 0;
  bit          cmdCheckEn = 1'b1;
  logic [15:0] rxCmd = '0;
  int          rxAddr = 0;

  always @(posedge eeSk or posedge eeCs) begin
    if (!eeSk) begin
      edgeCnt = 0;
      rxCmd   = '0;
      eeDo    = 1'b0;
      frameNo = frameNo + 1;
    end else if (eeCs) begin
      edgeCnt   = edgeCnt + 1;
      edgeTotal = edgeTotal + 1;
      if (edgeCnt <= devAw + 3) begin
        rxCmd = {rxCmd[14:0], eeDi};
        eeDo  = 1'b0;
        if (edgeCnt == devAw + 3) begin
          int rel;
          int expA;
          rxAddr = int'(rxCmd) & ((1 << devAw) - 1);
          rel    = frameNo - runBase;
          expA   = (rel == 1) ? 0 : FIRST + rel - 2;
          if (cmdCheckEn || rel == 1)
            if (((int'(rxCmd) >> devAw) & 7) != 6 || rxAddr != expA) begin
              cmdErr = cmdErr + 1;
              $display("FAIL R1 frame %0d cmd=%h expected op 6 addr %0d", rel, rxCmd, expA);
            end
        end
      end else begin
        int j;
        j = edgeCnt - devAw - 4;
        eeDo = (j < 16) ? mem[rxAddr][15-j] : 1'b0;
      end
    end
  end

  // port monitors
  int  doneTotal = 0;
  int  hiRun = 0;
  int  diErr = 0;
  int  csErr = 0;
  int  skErr = 0;
  logic prevSk = 1'b0;
  logic prevDi = 1'b0;
  logic prevCs = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneTotal++;
      if (eeSk && prevSk && eeDi != prevDi) diErr++;
      if (eeCs != prevCs && (eeSk || prevSk)) csErr++;
      if (eeSk) hiRun++;
      else begin
        if (prevSk && hiRun != HALF) skErr++;
        hiRun = 0;
      end
    end
    prevSk = eeSk;
    prevDi = eeDi;
    prevCs = eeCs;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishAll();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  task automatic runCase(input int aw, input logic [15:0] w0, input logic [15:0] w7,
                         input logic [15:0] w8, input logic [15:0] w9, input bit poke);
    logic [15:0] probe;
    bit          expWide;
    int          expEdges, e0, d0, di0, cs0, sk0, ce0, waitCnt;
    for (int k = 0; k < 256; k++) mem[k] = 16'hFFFF;
    mem[0] = w0; mem[FIRST] = w7; mem[FIRST+1] = w8; mem[FIRST+2] = w9;
    devAw   = aw;
    probe   = (aw == 8) ? w0 : 16'(w0 << 2);
    expWide = (probe == SIG);
    cmdCheckEn = ((expWide ? 8 : 6) == aw);
    expEdges = 27 + 3 * (19 + (expWide ? 8 : 6));
    runBase = frameNo;
    e0 = edgeTotal; d0 = doneTotal; di0 = diErr; cs0 = csErr; sk0 = skErr; ce0 = cmdErr;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
      if (poke && waitCnt == 150) start = 1'b1;
      if (poke && waitCnt == 151) start = 1'b0;
    end
    check(done == 1'b1, "R8", "done reached", 64'(done), 64'd1);
    check(busy == 1'b0, "R8", "busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", 64'(done), 64'd0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && eeCs == 1'b0, "R6", "idle after done", {62'd0, busy, eeCs}, 64'd0);
    check(wideAddr == expWide, "R2", "width detect", 64'(wideAddr), 64'(expWide));
    if (cmdCheckEn)
      check(stationAddr == {w9, w8, w7}, "R3", "station address",
            64'(stationAddr), 64'({w9, w8, w7}));
    check(edgeTotal - e0 == expEdges, "R4", "rising edges", 64'(edgeTotal - e0), 64'(expEdges));
    check(cmdErr == ce0, "R1", "command frames", 64'(cmdErr - ce0), 64'd0);
    check(diErr == di0, "R5", "di held while clock high", 64'(diErr - di0), 64'd0);
    check(csErr == cs0, "R6", "cs edges with clock low", 64'(csErr - cs0), 64'd0);
    check(skErr == sk0, "R7", "clock high width", 64'(skErr - sk0), 64'd0);
    check(doneTotal - d0 == 1, poke ? "R9" : "R8", "done pulses",
          64'(doneTotal - d0), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    finishAll();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({eeCs, eeSk, eeDi, busy, done, wideAddr} == 6'd0 && stationAddr == '0,
          "R10", "reset outputs", {10'd0, stationAddr, eeCs, eeSk, eeDi, busy, done, wideAddr}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(eeCs == 1'b0 && busy == 1'b0, "R10", "idle after reset", {62'd0, eeCs, busy}, 64'd0);

    // R2/R3 sweep across both widths and word patterns
    for (int i = 0; i < 6; i++) begin
      int aw;
      logic [15:0] w0;
      aw = (i % 2 == 0) ? 8 : 6;
      w0 = (aw == 8) ? SIG : 16'(16'h2040 ^ i);
      runCase(aw, w0, 16'(16'hA5C3 ^ (i * 16'h1357)), 16'(16'h0F1E + i * 16'h2222),
              16'(16'hC001 ^ (i << 9)), 1'b0);
    end
    // boundary words: all zeros and all ones
    runCase(8, SIG, 16'h0000, 16'hFFFF, 16'h0000, 1'b0);
    runCase(6, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0);
    // R2: near-miss signature on a wide part picks narrow addressing
    runCase(8, 16'h8128, 16'h1234, 16'h5678, 16'h9ABC, 1'b0);
    // R2: signature seen by a narrow part is shifted, so narrow stays
    runCase(6, SIG, 16'h1111, 16'h2222, 16'h3333, 1'b0);
    // R9: extra start while busy
    runCase(8, SIG, 16'hBEEF, 16'hCAFE, 16'hF00D, 1'b1);
    runCase(6, 16'h0001, 16'h0102, 16'h0304, 16'h0506, 1'b1);
    finishAll();
  end
endmodule